// File: doc/BRIEF.md
# Corner-Shifted Kernel Intensity Accumulator

This block builds a small tile of optical image intensity for a layout made of axis-aligned rectangles. The mask is never rasterised. Instead, each rectangle is replaced by its four corners. For every kernel, the block adds or subtracts a copy of that kernel's sample array into an on-chip partial image. Each copy is displaced by one corner. When all corners of a kernel have been applied, each partial-image value is squared, multiplied by the kernel's weight and added into the intensity image.

The work runs in a fixed nesting:
- the kernel loop is outermost;
- the corner loop sits inside it;
- the pixel loop is innermost and sweeps the whole tile at one pixel per clock.

All values are signed or unsigned fixed-point integers. Kernel samples, kernel weights and rectangle coordinates are written through plain write ports while the block is idle. A start pulse then runs the whole tile. A one-cycle done pulse marks the moment the intensity image is final. The image is read back through a registered read port.

Top module: `cska_engine`

## Requirements
- R1: While reset is asserted, `busy`, `done` and `rd_data` are all zero.
- R2: Pixel (x,y) is stored at read address y*IMG_W+x. Kernel sample (dx,dy) lives at tap dy*KER_W+dx. Rectangle r uses corners taken in the order (x1,y1) added, (x2,y1) subtracted, (x2,y2) added, (x1,y2) subtracted. For one kernel with weight w, the intensity equals w·P², where P is the sum over all rectangles and corners of ±sample(x−xc, y−yc).
- R3: A displaced coordinate with dx or dy outside 0..KER_W−1 / 0..KER_H−1 contributes zero. This also holds for corners with negative coordinates or coordinates beyond the tile.
- R4: With `cfg_kernels_m1` = n−1, the intensity is the sum over kernels 0..n−1 of weightₖ·Pₖ².
- R5: The partial image starts from zero for every kernel, so no kernel's P contains samples of an earlier kernel.
- R6: Every accepted start clears the intensity image first, so repeating a tile gives the same values rather than a sum.
- R7: `done` is a one-cycle pulse that rises exactly N+1 clock edges after the edge that samples `start`, where N = IMG_W·IMG_H·(1 + n·(4·cfg_rects + 1)). `busy` falls at that same edge.
- R8: `start` is accepted only while idle, and `busy` is high from the next edge. A start pulse during a run changes neither its length nor its result.
- R9: `rd_data` shows the intensity at the `rd_addr` sampled on the previous clock edge and holds until the next edge.
- R10: With `cfg_rects` = 0, every intensity value is zero and the run length follows R7 with no corner passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ker_we | input | 1 | Kernel sample write strobe |
| ker_sel | input | KIDX_W | Kernel index for the sample write |
| ker_tap | input | TAP_W | Tap index dy*KER_W+dx |
| ker_data | input | SAMP_W | Signed kernel sample |
| wgt_we | input | 1 | Kernel weight write strobe |
| wgt_sel | input | KIDX_W | Kernel index for the weight write |
| wgt_data | input | WGT_W | Unsigned kernel weight |
| rect_we | input | 1 | Rectangle write strobe |
| rect_sel | input | RIDX_W | Rectangle index |
| rect_x1 | input | COORD_W | Signed first x edge |
| rect_y1 | input | COORD_W | Signed first y edge |
| rect_x2 | input | COORD_W | Signed second x edge |
| rect_y2 | input | COORD_W | Signed second y edge |
| start | input | 1 | Begin a tile run |
| cfg_kernels_m1 | input | KIDX_W | Number of kernels minus one |
| cfg_rects | input | RCNT_W | Number of rectangles, 0..NUM_RECT |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| rd_addr | input | PIX_W | Intensity read address |
| rd_data | output | INT_W | Intensity at the previously sampled address |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a start pulse and an ongoing run. The bench raises `start` a few cycles into a run. The run counts as correct only if its `done` arrives at the cycle number the formula predicts and the image matches the model.

The second pair is the final squared write and the release of `busy` and `done`. The bench begins reading the image in the cycle after `done`. Any pixel whose last write landed late would then show a stale value against the bench's own computation over random kernels, weights and rectangles. Directed cases cover corners outside the kernel support, a zero-weight first kernel and an empty rectangle list.

// File: rtl/cska_pkg.sv
package cska_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CLR  = 2'd1,
      PH_ACC  = 2'd2,
      PH_SQR  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      OP_CLR = 2'd0,
      OP_ACC = 2'd1,
      OP_SQR = 2'd2
   } op_e;

   // corner order 0..3: (x1,y1)+ (x2,y1)- (x2,y2)+ (x1,y2)-
   function automatic logic corner_neg(input logic [1:0] c);
      return c[0];
   endfunction

   function automatic logic corner_x2(input logic [1:0] c);
      return (c == 2'd1) || (c == 2'd2);
   endfunction

   function automatic logic corner_y2(input logic [1:0] c);
      return c[1];
   endfunction

endpackage

// File: rtl/cska_seq.sv
module cska_seq import cska_pkg::*; #(
   parameter int IMG_W  = 8,
   parameter int IMG_H  = 8,
   parameter int KIDX_W = 2,
   parameter int RIDX_W = 2,
   parameter int RCNT_W = 3,
   parameter int PX_W   = 3,
   parameter int PY_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [KIDX_W-1:0] cfg_kernels_m1,
   input  logic [RCNT_W-1:0] cfg_rects,
   output logic              op_valid,
   output op_e               op_kind,
   output logic [PX_W-1:0]   op_px,
   output logic [PY_W-1:0]   op_py,
   output logic [KIDX_W-1:0] op_k,
   output logic [RIDX_W-1:0] op_r,
   output logic [1:0]        op_c,
   output logic              op_last,
   output logic              busy
);

   phase_e            phase;
   logic [KIDX_W-1:0] nk_q;
   logic [RCNT_W-1:0] nr_q;
   logic              pix_last, k_last, r_last;
   phase_e            pass_phase;

   always_comb begin
      pix_last   = (op_px == PX_W'(IMG_W - 1)) && (op_py == PY_W'(IMG_H - 1));
      k_last     = (op_k == nk_q);
      r_last     = (RCNT_W'(op_r) + RCNT_W'(1)) == nr_q;
      pass_phase = (nr_q != '0) ? PH_ACC : PH_SQR;
      op_valid   = (phase != PH_IDLE);
      busy       = op_valid;
      op_last    = (phase == PH_SQR) && pix_last && k_last;
      case (phase)
         PH_ACC:  op_kind = OP_ACC;
         PH_SQR:  op_kind = OP_SQR;
         default: op_kind = OP_CLR;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         nk_q  <= '0;
         nr_q  <= '0;
         op_k  <= '0;
         op_r  <= '0;
         op_c  <= '0;
         op_px <= '0;
         op_py <= '0;
      end else if (phase == PH_IDLE) begin
         if (start) begin
            phase <= PH_CLR;
            nk_q  <= cfg_kernels_m1;
            nr_q  <= cfg_rects;
            op_k  <= '0;
            op_r  <= '0;
            op_c  <= '0;
            op_px <= '0;
            op_py <= '0;
         end
      end else begin
         if (op_px == PX_W'(IMG_W - 1)) begin
            op_px <= '0;
            op_py <= pix_last ? '0 : op_py + PY_W'(1);
         end else begin
            op_px <= op_px + PX_W'(1);
         end
         if (pix_last) begin
            case (phase)
               PH_CLR: phase <= pass_phase;
               PH_ACC: begin
                  if (op_c == 2'd3) begin
                     op_c <= '0;
                     if (r_last) begin
                        op_r  <= '0;
                        phase <= PH_SQR;
                     end else begin
                        op_r <= op_r + RIDX_W'(1);
                     end
                  end else begin
                     op_c <= op_c + 2'd1;
                  end
               end
               default: begin
                  if (k_last) begin
                     phase <= PH_IDLE;
                  end else begin
                     op_k  <= op_k + KIDX_W'(1);
                     phase <= pass_phase;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/cska_kstore.sv
module cska_kstore import cska_pkg::*; #(
   parameter int IMG_W    = 8,
   parameter int NUM_KER  = 4,
   parameter int NUM_RECT = 4,
   parameter int KER_W    = 4,
   parameter int KER_H    = 4,
   parameter int COORD_W  = 6,
   parameter int SAMP_W   = 8,
   parameter int WGT_W    = 8,
   parameter int KIDX_W   = 2,
   parameter int RIDX_W   = 2,
   parameter int TAP_W    = 4,
   parameter int PX_W     = 3,
   parameter int PY_W     = 3,
   parameter int PIX_W    = 6,
   parameter int VAL_W    = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ker_we,
   input  logic [KIDX_W-1:0]         ker_sel,
   input  logic [TAP_W-1:0]          ker_tap,
   input  logic signed [SAMP_W-1:0]  ker_data,
   input  logic                      wgt_we,
   input  logic [KIDX_W-1:0]         wgt_sel,
   input  logic [WGT_W-1:0]          wgt_data,
   input  logic                      rect_we,
   input  logic [RIDX_W-1:0]         rect_sel,
   input  logic signed [COORD_W-1:0] rect_x1,
   input  logic signed [COORD_W-1:0] rect_y1,
   input  logic signed [COORD_W-1:0] rect_x2,
   input  logic signed [COORD_W-1:0] rect_y2,
   input  logic                      op_valid,
   input  op_e                       op_kind,
   input  logic [PX_W-1:0]           op_px,
   input  logic [PY_W-1:0]           op_py,
   input  logic [KIDX_W-1:0]         op_k,
   input  logic [RIDX_W-1:0]         op_r,
   input  logic [1:0]                op_c,
   input  logic                      op_last,
   output logic [PIX_W-1:0]          s0_pix,
   output logic                      s1_valid,
   output op_e                       s1_kind,
   output logic [PIX_W-1:0]          s1_pix,
   output logic signed [VAL_W-1:0]   s1_val,
   output logic                      s1_last
);

   localparam int KTAPS = KER_W * KER_H;
   localparam int KA_W  = $clog2(NUM_KER * KTAPS);
   localparam int PM_W  = (PX_W > PY_W) ? PX_W : PY_W;
   localparam int DW    = ((COORD_W > PM_W + 1) ? COORD_W : PM_W + 1) + 1;

   logic signed [SAMP_W-1:0]  ker_mem [NUM_KER*KTAPS];
   logic [WGT_W-1:0]          wgt_mem [NUM_KER];
   logic signed [COORD_W-1:0] rx1 [NUM_RECT];
   logic signed [COORD_W-1:0] ry1 [NUM_RECT];
   logic signed [COORD_W-1:0] rx2 [NUM_RECT];
   logic signed [COORD_W-1:0] ry2 [NUM_RECT];

   always_ff @(posedge clk) begin
      if (ker_we)  ker_mem[KA_W'(int'(ker_sel) * KTAPS + int'(ker_tap))] <= ker_data;
      if (wgt_we)  wgt_mem[wgt_sel] <= wgt_data;
      if (rect_we) begin
         rx1[rect_sel] <= rect_x1;
         ry1[rect_sel] <= rect_y1;
         rx2[rect_sel] <= rect_x2;
         ry2[rect_sel] <= rect_y2;
      end
   end

   logic signed [COORD_W-1:0] xc, yc;
   logic signed [DW-1:0]      dx, dy;
   logic                      in_sup;
   logic [KA_W-1:0]           ka;
   logic signed [VAL_W-1:0]   samp, val_c;

   always_comb begin
      s0_pix = PIX_W'(int'(op_py) * IMG_W + int'(op_px));
      xc     = corner_x2(op_c) ? rx2[op_r] : rx1[op_r];
      yc     = corner_y2(op_c) ? ry2[op_r] : ry1[op_r];
      dx     = DW'(signed'({1'b0, op_px})) - DW'(xc);
      dy     = DW'(signed'({1'b0, op_py})) - DW'(yc);
      in_sup = (dx >= 0) && (dx < DW'(KER_W)) && (dy >= 0) && (dy < DW'(KER_H));
      ka     = KA_W'(int'(op_k) * KTAPS + int'(dy) * KER_W + int'(dx));
      samp   = VAL_W'(ker_mem[ka]);
      if (op_kind == OP_SQR)  val_c = VAL_W'(wgt_mem[op_k]);
      else if (!in_sup)       val_c = '0;
      else if (corner_neg(op_c)) val_c = -samp;
      else                    val_c = samp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_last  <= 1'b0;
         s1_kind  <= OP_CLR;
         s1_pix   <= '0;
         s1_val   <= '0;
      end else begin
         s1_valid <= op_valid;
         s1_last  <= op_valid && op_last;
         s1_kind  <= op_kind;
         s1_pix   <= s0_pix;
         s1_val   <= val_c;
      end
   end

endmodule

// File: rtl/cska_accum.sv
module cska_accum import cska_pkg::*; #(
   parameter int NPIX   = 64,
   parameter int PIX_W  = 6,
   parameter int PS_W   = 13,
   parameter int INT_W  = 36,
   parameter int VAL_W  = 9,
   parameter int WGT_W  = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    s0_valid,
   input  logic [PIX_W-1:0]        s0_pix,
   input  logic                    s1_valid,
   input  op_e                     s1_kind,
   input  logic [PIX_W-1:0]        s1_pix,
   input  logic signed [VAL_W-1:0] s1_val,
   input  logic                    s1_last,
   input  logic [PIX_W-1:0]        rd_addr,
   output logic                    done,
   output logic [INT_W-1:0]        rd_data
);

   logic signed [PS_W-1:0]   ps_mem [NPIX];
   logic [INT_W-1:0]         in_mem [NPIX];
   logic signed [PS_W-1:0]   ps_q, ps_nxt;
   logic [INT_W-1:0]         in_q, in_nxt, term;
   logic signed [2*PS_W-1:0] sq;
   logic                     fwd;

   always_comb begin
      sq     = ps_q * ps_q;
      term   = INT_W'($unsigned(sq)) * INT_W'(s1_val[WGT_W-1:0]);
      ps_nxt = '0;
      in_nxt = in_q;
      case (s1_kind)
         OP_ACC:  ps_nxt = ps_q + PS_W'(s1_val);
         OP_SQR:  in_nxt = in_q + term;
         default: in_nxt = '0;
      endcase
      fwd = s1_valid && (s1_pix == s0_pix);
   end

   always_ff @(posedge clk) begin
      if (s1_valid) begin
         ps_mem[s1_pix] <= ps_nxt;
         in_mem[s1_pix] <= in_nxt;
      end
   end

   // read stage with bypass of the write landing on the same edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_q <= '0;
         in_q <= '0;
         done <= 1'b0;
      end else begin
         done <= s1_valid && s1_last;
         if (s0_valid) begin
            ps_q <= fwd ? ps_nxt : ps_mem[s0_pix];
            in_q <= fwd ? in_nxt : in_mem[s0_pix];
         end
      end
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rd_data <= '0;
            else        rd_data <= in_mem[rd_addr];
         end
      end else begin : g_rd_comb
         assign rd_data = rst_n ? in_mem[rd_addr] : '0;
      end
   endgenerate

endmodule

// File: rtl/cska_engine.sv
module cska_engine import cska_pkg::*; #(
   parameter int IMG_W    = 8,
   parameter int IMG_H    = 8,
   parameter int KER_W    = 4,
   parameter int KER_H    = 4,
   parameter int NUM_KER  = 4,
   parameter int NUM_RECT = 4,
   parameter int COORD_W  = 6,
   parameter int SAMP_W   = 8,
   parameter int WGT_W    = 8,
   parameter bit RD_REG   = 1'b1,
   // derived widths, not meant to be overridden
   parameter int KIDX_W   = $clog2(NUM_KER),
   parameter int RIDX_W   = $clog2(NUM_RECT),
   parameter int RCNT_W   = $clog2(NUM_RECT + 1),
   parameter int TAP_W    = $clog2(KER_W * KER_H),
   parameter int PIX_W    = $clog2(IMG_W * IMG_H),
   parameter int INT_W    = 2 * (SAMP_W + $clog2(4 * NUM_RECT) + 1) + WGT_W + $clog2(NUM_KER)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ker_we,
   input  logic [KIDX_W-1:0]         ker_sel,
   input  logic [TAP_W-1:0]          ker_tap,
   input  logic signed [SAMP_W-1:0]  ker_data,
   input  logic                      wgt_we,
   input  logic [KIDX_W-1:0]         wgt_sel,
   input  logic [WGT_W-1:0]          wgt_data,
   input  logic                      rect_we,
   input  logic [RIDX_W-1:0]         rect_sel,
   input  logic signed [COORD_W-1:0] rect_x1,
   input  logic signed [COORD_W-1:0] rect_y1,
   input  logic signed [COORD_W-1:0] rect_x2,
   input  logic signed [COORD_W-1:0] rect_y2,
   input  logic                      start,
   input  logic [KIDX_W-1:0]         cfg_kernels_m1,
   input  logic [RCNT_W-1:0]         cfg_rects,
   output logic                      busy,
   output logic                      done,
   input  logic [PIX_W-1:0]          rd_addr,
   output logic [INT_W-1:0]          rd_data
);

   localparam int NPIX  = IMG_W * IMG_H;
   localparam int PX_W  = $clog2(IMG_W);
   localparam int PY_W  = $clog2(IMG_H);
   localparam int PS_W  = SAMP_W + $clog2(4 * NUM_RECT) + 1;
   localparam int VAL_W = (SAMP_W > WGT_W) ? SAMP_W + 1 : WGT_W + 1;

   generate
      if (IMG_W < 2 || IMG_H < 2) begin : g_bad_tile
         $error("tile must be at least 2x2");
      end
      if (NUM_KER < 2 || NUM_RECT < 2 || KER_W < 2 || KER_H < 2) begin : g_bad_count
         $error("kernel count, rectangle count and kernel support must be at least 2");
      end
      if (INT_W < 2 * PS_W + WGT_W) begin : g_bad_int
         $error("intensity width cannot hold one weighted square");
      end
   endgenerate

   logic              op_valid, op_last, seq_busy;
   op_e               op_kind;
   logic [PX_W-1:0]   op_px;
   logic [PY_W-1:0]   op_py;
   logic [KIDX_W-1:0] op_k;
   logic [RIDX_W-1:0] op_r;
   logic [1:0]        op_c;
   logic [PIX_W-1:0]  s0_pix, s1_pix;
   logic              s1_valid, s1_last;
   op_e               s1_kind;
   logic signed [VAL_W-1:0] s1_val;

   cska_seq #(
      .IMG_W(IMG_W), .IMG_H(IMG_H), .KIDX_W(KIDX_W), .RIDX_W(RIDX_W),
      .RCNT_W(RCNT_W), .PX_W(PX_W), .PY_W(PY_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_kernels_m1(cfg_kernels_m1), .cfg_rects(cfg_rects),
      .op_valid(op_valid), .op_kind(op_kind), .op_px(op_px), .op_py(op_py),
      .op_k(op_k), .op_r(op_r), .op_c(op_c), .op_last(op_last), .busy(seq_busy)
   );

   cska_kstore #(
      .IMG_W(IMG_W), .NUM_KER(NUM_KER), .NUM_RECT(NUM_RECT), .KER_W(KER_W),
      .KER_H(KER_H), .COORD_W(COORD_W), .SAMP_W(SAMP_W), .WGT_W(WGT_W),
      .KIDX_W(KIDX_W), .RIDX_W(RIDX_W), .TAP_W(TAP_W), .PX_W(PX_W),
      .PY_W(PY_W), .PIX_W(PIX_W), .VAL_W(VAL_W)
   ) u_kst (
      .clk(clk), .rst_n(rst_n),
      .ker_we(ker_we), .ker_sel(ker_sel), .ker_tap(ker_tap), .ker_data(ker_data),
      .wgt_we(wgt_we), .wgt_sel(wgt_sel), .wgt_data(wgt_data),
      .rect_we(rect_we), .rect_sel(rect_sel), .rect_x1(rect_x1),
      .rect_y1(rect_y1), .rect_x2(rect_x2), .rect_y2(rect_y2),
      .op_valid(op_valid), .op_kind(op_kind), .op_px(op_px), .op_py(op_py),
      .op_k(op_k), .op_r(op_r), .op_c(op_c), .op_last(op_last),
      .s0_pix(s0_pix), .s1_valid(s1_valid), .s1_kind(s1_kind),
      .s1_pix(s1_pix), .s1_val(s1_val), .s1_last(s1_last)
   );

   cska_accum #(
      .NPIX(NPIX), .PIX_W(PIX_W), .PS_W(PS_W), .INT_W(INT_W),
      .VAL_W(VAL_W), .WGT_W(WGT_W), .RD_REG(RD_REG)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .s0_valid(op_valid), .s0_pix(s0_pix),
      .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_pix(s1_pix),
      .s1_val(s1_val), .s1_last(s1_last), .rd_addr(rd_addr),
      .done(done), .rd_data(rd_data)
   );

   assign busy = seq_busy | s1_valid;

endmodule

// File: rtl/cska_engine_chk.sv
module cska_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done
);

   AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);          // R7
   AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);          // R7
   AST_DONE_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));    // R7
   AST_BUSY_END:     assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);    // R7
   AST_BUSY_START:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R8

endmodule

bind cska_engine cska_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/sim_cska_engine.sv
`timescale 1ns/1ps
module sim_cska_engine;

   localparam int IW = 8, IH = 8, KW = 4, KH = 4, NK = 4, NR = 4;
   localparam int NPIX = IW * IH, KT = KW * KH;

   logic              clk, rst_n;
   logic              ker_we, wgt_we, rect_we, start, busy, done;
   logic [1:0]        ker_sel, wgt_sel, rect_sel, cfg_kernels_m1;
   logic [3:0]        ker_tap;
   logic signed [7:0] ker_data;
   logic [7:0]        wgt_data;
   logic signed [5:0] rect_x1, rect_y1, rect_x2, rect_y2;
   logic [2:0]        cfg_rects;
   logic [5:0]        rd_addr;
   logic [35:0]       rd_data;

   cska_engine u0 (
      .clk(clk), .rst_n(rst_n), .ker_we(ker_we), .ker_sel(ker_sel),
      .ker_tap(ker_tap), .ker_data(ker_data), .wgt_we(wgt_we),
      .wgt_sel(wgt_sel), .wgt_data(wgt_data), .rect_we(rect_we),
      .rect_sel(rect_sel), .rect_x1(rect_x1), .rect_y1(rect_y1),
      .rect_x2(rect_x2), .rect_y2(rect_y2), .start(start),
      .cfg_kernels_m1(cfg_kernels_m1), .cfg_rects(cfg_rects),
      .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   int bk [NK][KT];
   int bw [NK];
   int bx1 [NR], by1 [NR], bx2 [NR], by2 [NR];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rnd(input int lo, input int hi);
      return lo + int'($urandom % (hi - lo + 1));
   endfunction

   function automatic longint model_pix(input int nk, input int nr, input int x, input int y);
      longint acc;
      acc = 0;
      for (int k = 0; k < nk; k++) begin
         longint ps;
         ps = 0;
         for (int r = 0; r < nr; r++) begin
            for (int c = 0; c < 4; c++) begin
               int xc, yc, dx, dy;
               xc = (c == 1 || c == 2) ? bx2[r] : bx1[r];
               yc = (c >= 2) ? by2[r] : by1[r];
               dx = x - xc;
               dy = y - yc;
               if (dx >= 0 && dx < KW && dy >= 0 && dy < KH)
                  ps += (c % 2 == 1) ? -bk[k][dy*KW+dx] : bk[k][dy*KW+dx];
            end
         end
         acc += longint'(bw[k]) * ps * ps;
      end
      return acc;
   endfunction

   task automatic load_all();
      for (int k = 0; k < NK; k++) begin
         for (int t = 0; t < KT; t++) begin
            ker_we = 1; ker_sel = 2'(k); ker_tap = 4'(t); ker_data = 8'(bk[k][t]);
            @(posedge clk); #1;
         end
         ker_we = 0;
         wgt_we = 1; wgt_sel = 2'(k); wgt_data = 8'(bw[k]);
         @(posedge clk); #1;
         wgt_we = 0;
      end
      for (int r = 0; r < NR; r++) begin
         rect_we = 1; rect_sel = 2'(r);
         rect_x1 = 6'(bx1[r]); rect_y1 = 6'(by1[r]);
         rect_x2 = 6'(bx2[r]); rect_y2 = 6'(by2[r]);
         @(posedge clk); #1;
      end
      rect_we = 0;
   endtask

   task automatic rand_all();
      for (int k = 0; k < NK; k++) begin
         for (int t = 0; t < KT; t++) bk[k][t] = rnd(-128, 127);
         bw[k] = rnd(0, 255);
      end
      for (int r = 0; r < NR; r++) begin
         bx1[r] = rnd(-4, 8); by1[r] = rnd(-4, 8);
         bx2[r] = bx1[r] + rnd(1, 5); by2[r] = by1[r] + rnd(1, 5);
      end
   endtask

   task automatic run_tile(input int nkm1, input int nr, input int poke, input string req);
      int n_exp, cyc;
      bit got;
      n_exp = NPIX * (1 + (nkm1 + 1) * (4 * nr + 1));
      cfg_kernels_m1 = 2'(nkm1); cfg_rects = 3'(nr); start = 1;
      @(posedge clk); #1;
      start = 0;
      cyc = 0; got = 0;
      while (!got && cyc < 20000) begin
         @(posedge clk); cyc++; #1;
         if (cyc == 1) check(busy == 1'b1, "R8 busy after start", longint'(busy), 1);
         if (done) got = 1;
         start = (poke > 0 && cyc == poke);
      end
      start = 0;
      check(cyc == n_exp + 1, {"R7 done cycle ", req}, cyc, n_exp + 1);
      check(busy == 1'b0, "R7 busy low at done", longint'(busy), 0);
      @(posedge clk); #1;
      check(done == 1'b0, "R7 done single pulse", longint'(done), 0);
   endtask

   task automatic check_image(input int nk, input int nr, input string req);
      for (int p = 0; p < NPIX; p++) begin
         longint e;
         rd_addr = 6'(p);
         @(posedge clk); #1;
         e = model_pix(nk, nr, p % IW, p / IW);
         check(longint'(rd_data) == e, req, longint'(rd_data), e);
      end
   endtask

   initial begin
      longint ea, eb;
      void'($urandom(32'd918273));
      rst_n = 0; ker_we = 0; wgt_we = 0; rect_we = 0; start = 0;
      ker_sel = 0; ker_tap = 0; ker_data = 0; wgt_sel = 0; wgt_data = 0;
      rect_sel = 0; rect_x1 = 0; rect_y1 = 0; rect_x2 = 0; rect_y2 = 0;
      cfg_kernels_m1 = 0; cfg_rects = 0; rd_addr = 0;
      repeat (3) @(posedge clk);
      #1;
      check(busy == 1'b0, "R1 busy in reset", longint'(busy), 0);
      check(done == 1'b0, "R1 done in reset", longint'(done), 0);
      check(rd_data == '0, "R1 rd_data in reset", longint'(rd_data), 0);
      rst_n = 1;

      // R2: one kernel, one rectangle inside the tile
      rand_all();
      for (int t = 0; t < KT; t++) bk[0][t] = t + 1;
      bw[0] = 3;
      bx1[0] = 1; by1[0] = 1; bx2[0] = 3; by2[0] = 4;
      load_all();
      run_tile(0, 1, 0, "R2");
      check_image(1, 1, "R2 single kernel image");

      // R9: read latency and hold
      ea = model_pix(1, 1, 2, 2); eb = model_pix(1, 1, 1, 1);
      rd_addr = 6'(2 * IW + 2);
      @(posedge clk); #1;
      rd_addr = 6'(1 * IW + 1);
      #2;
      check(longint'(rd_data) == ea, "R9 holds before edge", longint'(rd_data), ea);
      @(posedge clk); #1;
      check(longint'(rd_data) == eb, "R9 new address after edge", longint'(rd_data), eb);

      // R3: corners outside the tile and outside the kernel support
      rand_all();
      bx1[0] = -3; by1[0] = -3; bx2[0] = 1;  by2[0] = 2;
      bx1[1] = 6;  by1[1] = 5;  bx2[1] = 12; by2[1] = 11;
      bx1[2] = 20; by1[2] = 20; bx2[2] = 25; by2[2] = 25;
      load_all();
      run_tile(0, 3, 0, "R3");
      check_image(1, 3, "R3 out-of-support zero");

      // R4: random multi-kernel tiles
      for (int i = 0; i < 3; i++) begin
         int nkm1, nr;
         rand_all();
         nkm1 = rnd(1, 3); nr = rnd(1, 4);
         load_all();
         run_tile(nkm1, nr, 0, "R4");
         check_image(nkm1 + 1, nr, "R4 weighted kernel sum");
      end

      // R5: zero weight on the first kernel exposes any carried partial sum
      rand_all();
      bw[0] = 0; bw[1] = 1;
      load_all();
      run_tile(1, 2, 0, "R5");
      check_image(2, 2, "R5 partial cleared per kernel");

      // R6: repeat the same tile, intensity must not double
      run_tile(1, 2, 0, "R6");
      check_image(2, 2, "R6 intensity cleared per tile");

      // R8: start pulse during a run
      rand_all();
      load_all();
      run_tile(3, 2, 7, "R8 with start during run");
      check_image(4, 2, "R8 result unchanged by start in run");

      // R10: no rectangles
      run_tile(1, 0, 0, "R10");
      check_image(2, 0, "R10 zero rectangles");

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule